// File: doc/BRIEF.md
# Flash Controller Command Interface

This block is the command front end of an embedded flash controller. Software reaches it through a small 32-bit register port. It writes a command word that carries a guard key, an opcode and a 16-bit argument. The block checks the word and then works on two state arrays: the page-lock regions and the general-purpose non-volatile (GPNVM) bits. It reports progress and errors through a status register and returns query answers in a result register.

The flash array is not part of the block. Page programming and erasing are modelled as a busy interval whose length software sets in the mode register, and a lock check comes first. Commands that only touch the lock or GPNVM state take a short fixed busy interval. Software issues a command, polls the ready bit, and treats either error bit as a failure.

The register port takes requests on a valid/ready handshake. `req_ready` is held high, so a request is accepted in every cycle that `req_valid` is high and no back-pressure exists. A read returns its data with a one-cycle `rsp_valid` pulse on the clock after it is accepted. The response has no ready signal, so the requester must take it in that cycle.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset, status reads 0x1 (ready set, both error bits clear), the result register reads 0, the mode register reads DEFAULT_DELAY (4), and the lock and GPNVM vectors hold their reset parameters (all zero by default).
- R2: A write to the command register whose bits 31:24 differ from 0x5A is ignored: no error bit is set, ready stays 1, and no lock, GPNVM or result state changes.
- R3: A keyed command that passes its checks drops ready to 0 on the next clock. Flash operations (opcodes 0x01 to 0x05 and 0x07) keep ready low for the mode register count, and a count of 0 is treated as 1. All other accepted opcodes keep it low for CTRL_CYCLES (2).
- R4: A command written while ready is 0 is ignored entirely.
- R5: An opcode outside the defined set (0x06, or above 0x0F), or an argument out of range, sets the command error flag (status bit 1). It changes no state and ready stays 1.
- R6: Opcodes 0x01 to 0x04 take a page number in the argument (bits 23:8), which must be below NUM_PAGES (64). The lock region of a page is the page number divided by PAGES_PER_LOCK (8). If that region is locked, the lock error flag (status bit 2) is set and nothing changes. On success, opcodes 0x02 and 0x04 also lock that region.
- R7: Opcode 0x05 (erase whole array) raises lock error if any region is locked.
- R8: Opcode 0x07 erases a page group. Argument bits 1:0 select the size as 4 shifted left by that value (4, 8, 16 or 32 pages). The start page is the argument with bits 1:0 cleared. A start that is not aligned to the group size, or a group that runs past the last page, is a command error. A group that overlaps any locked region is a lock error.
- R9: Opcodes 0x08 and 0x09 set and clear the lock region of the page given in the argument (page must be below 64). Opcode 0x0A loads the lock vector into the result register, with region n at bit n.
- R10: Opcodes 0x0B and 0x0C set and clear the GPNVM bit whose index is the argument. The index must be below GPNVM_BITS (9) and its bit must be set in GPNVM_MASK (0x1BF), otherwise the command is a command error. Opcode 0x0D loads the GPNVM vector into the result register, with bit n at bit n.
- R11: Opcode 0x00 loads the descriptor into the result register: {NUM_PAGES[15:0], region count[7:0], GPNVM_BITS[7:0]}, which is 0x00400809 by default. Opcode 0x0E loads UID_WORD (0xC0DE1234). Opcode 0x0F leaves the result register unchanged.
- R12: Error flags are sticky across commands. A status read returns {lock error, command error, ready} in bits 2:0 and clears both error flags after returning them.
- R13: The register index is the byte offset divided by 4: 0 is mode, 1 is command, 2 is status, 3 is result. The mode register is readable and writable in its low DELAY_W bits. The command register reads as 0. Writes to status and result are ignored. Every accepted read gives `rsp_valid` on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted; held high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 2 | Register index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |

## Verification
The hardest situation to reach from the ports is a second command that arrives during the busy window of the first one. Software that polls ready never produces it. The stimulus sets a long mode count, issues a program command, and writes a lock command on the very next clock. It then checks through a lock query that the second command had no effect. Group erases that straddle lock regions, and sticky errors that stack up before a status read, are also built directly. After that, a fixed-seed random stream of keyed and unkeyed commands runs against a bench model of the lock and GPNVM state.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam logic [7:0] CMD_KEY = 8'h5A;

  localparam logic [7:0] OP_DESC      = 8'h00;
  localparam logic [7:0] OP_WR        = 8'h01;
  localparam logic [7:0] OP_WR_LK     = 8'h02;
  localparam logic [7:0] OP_EWR       = 8'h03;
  localparam logic [7:0] OP_EWR_LK    = 8'h04;
  localparam logic [7:0] OP_ERASE_ALL = 8'h05;
  localparam logic [7:0] OP_ERASE_GRP = 8'h07;
  localparam logic [7:0] OP_LK_SET    = 8'h08;
  localparam logic [7:0] OP_LK_CLR    = 8'h09;
  localparam logic [7:0] OP_LK_GET    = 8'h0A;
  localparam logic [7:0] OP_NV_SET    = 8'h0B;
  localparam logic [7:0] OP_NV_CLR    = 8'h0C;
  localparam logic [7:0] OP_NV_GET    = 8'h0D;
  localparam logic [7:0] OP_UID_ON    = 8'h0E;
  localparam logic [7:0] OP_UID_OFF   = 8'h0F;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_RES  = 2'd3
  } reg_sel_e;

  localparam int STB_READY   = 0;
  localparam int STB_CMDERR  = 1;
  localparam int STB_LOCKERR = 2;
endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
  import fcmd_pkg::*;
#(
  parameter int NUM_PAGES      = 64,
  parameter int PAGES_PER_LOCK = 8,
  parameter int GPNVM_BITS     = 9,
  parameter logic [GPNVM_BITS-1:0] GPNVM_MASK = 9'h1BF,
  parameter logic [31:0] UID_WORD = 32'hC0DE_1234
) (
  input  logic [31:0]                            cmd_word,
  input  logic [NUM_PAGES/PAGES_PER_LOCK-1:0]    lock_q,
  input  logic [GPNVM_BITS-1:0]                  gp_q,
  output logic                                   key_ok,
  output logic                                   cmd_err,
  output logic                                   lock_err,
  output logic                                   long_op,
  output logic [NUM_PAGES/PAGES_PER_LOCK-1:0]    lock_set,
  output logic [NUM_PAGES/PAGES_PER_LOCK-1:0]    lock_clr,
  output logic [GPNVM_BITS-1:0]                  gp_set,
  output logic [GPNVM_BITS-1:0]                  gp_clr,
  output logic                                   res_load,
  output logic [31:0]                            res_val
);
  localparam int LOCKS = NUM_PAGES / PAGES_PER_LOCK;

  logic [7:0]  code;
  logic [31:0] arg, page_region;
  logic [31:0] grp_size, grp_start, grp_end;
  logic        page_ok, grp_ok, gp_ok;
  logic [LOCKS-1:0]      page_hit, grp_hit;
  logic [GPNVM_BITS-1:0] gp_hit;

  assign code        = cmd_word[7:0];
  assign arg         = {16'h0, cmd_word[23:8]};
  assign key_ok      = cmd_word[31:24] == CMD_KEY;
  assign page_region = arg / 32'(PAGES_PER_LOCK);
  assign page_ok     = arg < 32'(NUM_PAGES);

  // group size 4 << arg[1:0], start page is the argument with bits 1:0 cleared
  assign grp_size  = 32'd4 << cmd_word[9:8];
  assign grp_start = {16'h0, cmd_word[23:10], 2'b00};
  assign grp_end   = grp_start + grp_size;
  assign grp_ok    = ((grp_start & (grp_size - 32'd1)) == 32'd0) &&
                     (grp_end <= 32'(NUM_PAGES));

  for (genvar r = 0; r < LOCKS; r++) begin : g_region
    localparam logic [31:0] LO = 32'(r * PAGES_PER_LOCK);
    localparam logic [31:0] HI = 32'((r + 1) * PAGES_PER_LOCK);
    assign page_hit[r] = page_region == 32'(r);
    assign grp_hit[r]  = (grp_start < HI) && (grp_end > LO);
  end

  for (genvar b = 0; b < GPNVM_BITS; b++) begin : g_gpbit
    assign gp_hit[b] = GPNVM_MASK[b] && (arg == 32'(b));
  end
  assign gp_ok = |gp_hit;

  always_comb begin
    cmd_err  = 1'b0;
    lock_err = 1'b0;
    long_op  = 1'b0;
    lock_set = '0;
    lock_clr = '0;
    gp_set   = '0;
    gp_clr   = '0;
    res_load = 1'b0;
    res_val  = '0;
    case (code)
      OP_DESC: begin
        res_load = 1'b1;
        res_val  = {16'(NUM_PAGES), 8'(LOCKS), 8'(GPNVM_BITS)};
      end
      OP_WR, OP_WR_LK, OP_EWR, OP_EWR_LK: begin
        if (!page_ok)                    cmd_err  = 1'b1;
        else if (|(page_hit & lock_q))   lock_err = 1'b1;
        else begin
          long_op = 1'b1;
          if (code == OP_WR_LK || code == OP_EWR_LK) lock_set = page_hit;
        end
      end
      OP_ERASE_ALL: begin
        if (|lock_q) lock_err = 1'b1;
        else         long_op  = 1'b1;
      end
      OP_ERASE_GRP: begin
        if (!grp_ok)                   cmd_err  = 1'b1;
        else if (|(grp_hit & lock_q))  lock_err = 1'b1;
        else                           long_op  = 1'b1;
      end
      OP_LK_SET: begin
        if (!page_ok) cmd_err  = 1'b1;
        else          lock_set = page_hit;
      end
      OP_LK_CLR: begin
        if (!page_ok) cmd_err  = 1'b1;
        else          lock_clr = page_hit;
      end
      OP_LK_GET: begin
        res_load = 1'b1;
        res_val[LOCKS-1:0] = lock_q;
      end
      OP_NV_SET: begin
        if (!gp_ok) cmd_err = 1'b1;
        else        gp_set  = gp_hit;
      end
      OP_NV_CLR: begin
        if (!gp_ok) cmd_err = 1'b1;
        else        gp_clr  = gp_hit;
      end
      OP_NV_GET: begin
        res_load = 1'b1;
        res_val[GPNVM_BITS-1:0] = gp_q;
      end
      OP_UID_ON: begin
        res_load = 1'b1;
        res_val  = UID_WORD;
      end
      OP_UID_OFF: ;
      default: cmd_err = 1'b1;
    endcase
  end
endmodule

// File: rtl/fcmd_bit_array.sv
module fcmd_bit_array #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        q[i] <= RESET_VAL[i];
      else if (set_i[i]) q[i] <= 1'b1;
      else if (clr_i[i]) q[i] <= 1'b0;
    end
  end

  // R9
  set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i & clr_i) == '0);

  // R9
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/fcmd_busy_timer.sv
module fcmd_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             ready
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= load;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign ready = cnt_q == '0;

  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);

  // R4
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ready);

  // R3
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> load != '0);

  // R3
  ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ready);
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import fcmd_pkg::*;
#(
  parameter int NUM_PAGES      = 64,
  parameter int PAGES_PER_LOCK = 8,
  parameter int GPNVM_BITS     = 9,
  parameter logic [GPNVM_BITS-1:0] GPNVM_MASK  = 9'h1BF,
  parameter logic [GPNVM_BITS-1:0] GPNVM_RESET = '0,
  parameter logic [NUM_PAGES/PAGES_PER_LOCK-1:0] LOCK_RESET = '0,
  parameter int DELAY_W       = 8,
  parameter int DEFAULT_DELAY = 4,
  parameter int CTRL_CYCLES   = 2,
  parameter logic [31:0] UID_WORD = 32'hC0DE_1234
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_index,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);
  localparam int LOCKS = NUM_PAGES / PAGES_PER_LOCK;

  reg_sel_e sel;
  logic wr, rd, cmd_try, cmd_fire, apply, ready;
  logic key_ok, cmd_err, lock_err, long_op, res_load;
  logic [LOCKS-1:0] lock_q, lock_set, lock_clr;
  logic [GPNVM_BITS-1:0] gp_q, gp_set, gp_clr;
  logic [31:0] res_val, result_q, rdata_d;
  logic [DELAY_W-1:0] mode_q, busy_load;
  logic cmd_err_q, lock_err_q;

  assign req_ready = 1'b1;
  assign sel      = reg_sel_e'(req_index);
  assign wr       = req_valid && req_write;
  assign rd       = req_valid && !req_write;
  assign cmd_try  = wr && sel == SEL_CMD && key_ok;
  assign cmd_fire = cmd_try && ready;
  assign apply    = cmd_fire && !cmd_err && !lock_err;

  fcmd_decode #(
    .NUM_PAGES(NUM_PAGES), .PAGES_PER_LOCK(PAGES_PER_LOCK),
    .GPNVM_BITS(GPNVM_BITS), .GPNVM_MASK(GPNVM_MASK), .UID_WORD(UID_WORD)
  ) u_decode (
    .cmd_word(req_wdata), .lock_q(lock_q), .gp_q(gp_q),
    .key_ok(key_ok), .cmd_err(cmd_err), .lock_err(lock_err), .long_op(long_op),
    .lock_set(lock_set), .lock_clr(lock_clr), .gp_set(gp_set), .gp_clr(gp_clr),
    .res_load(res_load), .res_val(res_val)
  );

  fcmd_bit_array #(.WIDTH(LOCKS), .RESET_VAL(LOCK_RESET)) u_locks (
    .clk(clk), .rst_n(rst_n),
    .set_i(lock_set & {LOCKS{apply}}), .clr_i(lock_clr & {LOCKS{apply}}),
    .q(lock_q)
  );

  fcmd_bit_array #(.WIDTH(GPNVM_BITS), .RESET_VAL(GPNVM_RESET)) u_gpnvm (
    .clk(clk), .rst_n(rst_n),
    .set_i(gp_set & {GPNVM_BITS{apply}}), .clr_i(gp_clr & {GPNVM_BITS{apply}}),
    .q(gp_q)
  );

  always_comb begin
    if (!long_op)            busy_load = DELAY_W'(CTRL_CYCLES);
    else if (mode_q == '0)   busy_load = DELAY_W'(1);
    else                     busy_load = mode_q;
  end

  fcmd_busy_timer #(.CNT_W(DELAY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(apply), .load(busy_load), .ready(ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= DELAY_W'(DEFAULT_DELAY);
      result_q   <= '0;
      cmd_err_q  <= 1'b0;
      lock_err_q <= 1'b0;
    end else begin
      if (wr && sel == SEL_MODE) mode_q <= req_wdata[DELAY_W-1:0];
      if (apply && res_load)     result_q <= res_val;
      if (rd && sel == SEL_STAT) begin
        cmd_err_q  <= 1'b0;
        lock_err_q <= 1'b0;
      end else if (cmd_fire) begin
        cmd_err_q  <= cmd_err_q | cmd_err;
        lock_err_q <= lock_err_q | lock_err;
      end
    end
  end

  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_MODE: rdata_d[DELAY_W-1:0] = mode_q;
      SEL_STAT: begin
        rdata_d[STB_READY]   = ready;
        rdata_d[STB_CMDERR]  = cmd_err_q;
        rdata_d[STB_LOCKERR] = lock_err_q;
      end
      SEL_RES:  rdata_d = result_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rdata_d;
    end
  end

  // R4
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_try && !ready) |=> ($stable(lock_q) && $stable(gp_q) && $stable(result_q)));

  // R6
  lock_err_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && lock_err) |=> ($stable(lock_q) && ready && lock_err_q));

  // R12
  stat_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_STAT) |=> (!cmd_err_q && !lock_err_q));

  // R2
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_CMD && !key_ok) |=>
      ($stable(lock_q) && $stable(gp_q) && $stable(cmd_err_q) && $stable(lock_err_q)));

  // R10
  gp_outside_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(gp_q & ~GPNVM_MASK));

  // R13
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
endmodule

// File: tb/test_flash_cmd_frontend.sv
module test_flash_cmd_frontend;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_index = 2'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;

  flash_cmd_frontend i_flash_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_index(req_index), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  localparam logic [8:0] GP_MASK = 9'h1BF;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0]  m_lock = '0;
  logic [8:0]  m_gp = '0;
  int          m_mode = 4;
  logic [31:0] m_res = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_index = idx; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] idx, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_index = idx;
    @(posedge clk); #1;
    req_valid = 1'b0;
    d = rsp_rdata;
    chk(rsp_valid === 1'b1, "R13", "rsp_valid after read", 32'(rsp_valid), 32'd1);
  endtask

  task automatic poll(output logic [31:0] first, output int zeros);
    logic [31:0] s;
    rd_reg(2'd2, first);
    s = first; zeros = 0;
    while (s[0] !== 1'b1 && zeros < 1000) begin
      zeros++;
      rd_reg(2'd2, s);
    end
  endtask

  function automatic string tag_of(input logic [7:0] c);
    case (c)
      8'h00, 8'h0E, 8'h0F: return "R11";
      8'h01, 8'h02, 8'h03, 8'h04: return "R6";
      8'h05: return "R7";
      8'h07: return "R8";
      8'h08, 8'h09, 8'h0A: return "R9";
      8'h0B, 8'h0C, 8'h0D: return "R10";
      default: return "R5";
    endcase
  endfunction

  function automatic int long_busy();
    return (m_mode == 0) ? 1 : m_mode;
  endfunction

  // bench model of the command set, updates the model state
  task automatic model_cmd(input logic [31:0] w, output bit ign, output bit ce,
                           output bit le, output int busy);
    logic [7:0] c;
    int a, sz, st;
    c = w[7:0]; a = int'(w[23:8]);
    ign = 0; ce = 0; le = 0; busy = 0;
    if (w[31:24] != 8'h5A) begin ign = 1; return; end
    case (c)
      8'h00: begin m_res = 32'h0040_0809; busy = 2; end
      8'h01, 8'h02, 8'h03, 8'h04: begin
        if (a >= 64) ce = 1;
        else if (m_lock[a/8]) le = 1;
        else begin
          busy = long_busy();
          if (c == 8'h02 || c == 8'h04) m_lock[a/8] = 1'b1;
        end
      end
      8'h05: begin
        if (m_lock != 0) le = 1; else busy = long_busy();
      end
      8'h07: begin
        sz = 4 << (a % 4); st = a - (a % 4);
        if ((st % sz) != 0 || st + sz > 64) ce = 1;
        else begin
          for (int p = st; p < st + sz; p++) if (m_lock[p/8]) le = 1;
          if (!le) busy = long_busy();
        end
      end
      8'h08, 8'h09: begin
        if (a >= 64) ce = 1;
        else begin m_lock[a/8] = (c == 8'h08); busy = 2; end
      end
      8'h0A: begin m_res = {24'h0, m_lock}; busy = 2; end
      8'h0B, 8'h0C: begin
        if (a >= 9 || !GP_MASK[a]) ce = 1;
        else begin m_gp[a] = (c == 8'h0B); busy = 2; end
      end
      8'h0D: begin m_res = {23'h0, m_gp}; busy = 2; end
      8'h0E: begin m_res = 32'hC0DE_1234; busy = 2; end
      8'h0F: busy = 2;
      default: ce = 1;
    endcase
  endtask

  task automatic do_cmd(input logic [31:0] w);
    bit ign, ce, le;
    int busy, z;
    string t;
    logic [31:0] st, r;
    model_cmd(w, ign, ce, le, busy);
    t = ign ? "R2" : tag_of(w[7:0]);
    wr_reg(2'd1, w);
    poll(st, z);
    chk(st[1] == ce, ce ? "R5" : t, "command error bit", 32'(st[1]), 32'(ce));
    chk(st[2] == le, t, "lock error bit", 32'(st[2]), 32'(le));
    chk(z == busy, (busy > 0) ? "R3" : t, "busy cycles", 32'(z), 32'(busy));
    rd_reg(2'd3, r);
    chk(r == m_res, t, "result register", r, m_res);
  endtask

  function automatic logic [31:0] mk(input logic [7:0] c, input int a);
    return {8'h5A, 16'(a), c};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit ign, ce, le;
    int busy, z;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd_reg(2'd2, d); chk(d == 32'h1, "R1", "status after reset", d, 32'h1);
    rd_reg(2'd3, d); chk(d == 32'h0, "R1", "result after reset", d, 32'h0);
    rd_reg(2'd0, d); chk(d == 32'd4, "R1", "mode after reset", d, 32'd4);
    chk(req_ready === 1'b1, "R13", "req_ready", 32'(req_ready), 32'd1);
    do_cmd(mk(8'h0A, 0));
    do_cmd(mk(8'h0D, 0));

    // R13: command reads 0, status/result writes ignored
    rd_reg(2'd1, d); chk(d == 32'h0, "R13", "command reg read", d, 32'h0);
    wr_reg(2'd3, 32'hFFFF_FFFF); wr_reg(2'd2, 32'hFFFF_FFFF);
    rd_reg(2'd3, d); chk(d == m_res, "R13", "result after write", d, m_res);
    rd_reg(2'd2, d); chk(d == 32'h1, "R13", "status after write", d, 32'h1);

    // R11
    do_cmd(mk(8'h00, 0));
    do_cmd(mk(8'h0E, 0));
    do_cmd(mk(8'h0F, 0));

    // R2: bad key ignored
    do_cmd({8'hA5, 16'd0, 8'h08});
    do_cmd({8'h00, 16'd0, 8'h0B});
    do_cmd(mk(8'h0A, 0));

    // R9 / R6 / R7
    do_cmd(mk(8'h08, 0));
    do_cmd(mk(8'h08, 17));
    do_cmd(mk(8'h0A, 0));
    do_cmd(mk(8'h01, 3));
    do_cmd(mk(8'h02, 9));
    do_cmd(mk(8'h03, 63));
    do_cmd(mk(8'h01, 64));
    do_cmd(mk(8'h05, 0));
    do_cmd(mk(8'h0A, 0));

    // R8: group erase corners
    do_cmd(mk(8'h07, 3));
    do_cmd(mk(8'h07, 41));
    do_cmd(mk(8'h07, 5));
    do_cmd(mk(8'h07, 62));
    do_cmd(mk(8'h07, 50));
    do_cmd(mk(8'h07, 16));
    do_cmd(mk(8'h07, 67));
    do_cmd(mk(8'h09, 1)); do_cmd(mk(8'h09, 9)); do_cmd(mk(8'h09, 17));
    do_cmd(mk(8'h05, 0));

    // R10
    do_cmd(mk(8'h0B, 0)); do_cmd(mk(8'h0B, 8)); do_cmd(mk(8'h0B, 6));
    do_cmd(mk(8'h0B, 9)); do_cmd(mk(8'h0D, 0)); do_cmd(mk(8'h0C, 0));
    do_cmd(mk(8'h0D, 0));

    // R5
    do_cmd(mk(8'h06, 0)); do_cmd(mk(8'h10, 0)); do_cmd(mk(8'hFF, 2));

    // R3: mode count 0 gives one busy cycle, 7 gives seven
    wr_reg(2'd0, 32'd0); m_mode = 0;
    rd_reg(2'd0, d); chk(d == 32'd0, "R13", "mode readback", d, 32'd0);
    do_cmd(mk(8'h01, 5));
    wr_reg(2'd0, 32'd7); m_mode = 7;
    do_cmd(mk(8'h03, 20));

    // R12: errors stack until status read
    do_cmd(mk(8'h08, 0));
    model_cmd(mk(8'h06, 0), ign, ce, le, busy);
    wr_reg(2'd1, mk(8'h06, 0));
    model_cmd(mk(8'h01, 3), ign, ce, le, busy);
    wr_reg(2'd1, mk(8'h01, 3));
    rd_reg(2'd2, d); chk(d == 32'h7, "R12", "stacked errors", d, 32'h7);
    rd_reg(2'd2, d); chk(d == 32'h1, "R12", "errors cleared by read", d, 32'h1);

    // R4: second command during busy window
    wr_reg(2'd0, 32'd30); m_mode = 30;
    model_cmd(mk(8'h01, 40), ign, ce, le, busy);
    wr_reg(2'd1, mk(8'h01, 40));
    wr_reg(2'd1, mk(8'h08, 56));
    poll(d, z);
    chk(z == 29, "R4", "remaining busy after ignored write", 32'(z), 32'd29);
    chk(d[2:1] == 2'b00, "R4", "no error from ignored write", 32'(d[2:1]), 32'd0);
    do_cmd(mk(8'h0A, 0));
    wr_reg(2'd0, 32'd4); m_mode = 4;

    // constrained random stream
    for (int i = 0; i < 300; i++) begin
      int pick, a;
      logic [7:0] c, key;
      pick = int'($urandom_range(0, 17));
      c = (pick < 16) ? 8'(pick) : ((pick == 16) ? 8'h06 : 8'h3C);
      if (c >= 8'h0B && c <= 8'h0D) a = int'($urandom_range(0, 10));
      else if ($urandom_range(0, 9) < 8) a = int'($urandom_range(0, 67));
      else a = int'($urandom_range(0, 65535));
      key = ($urandom_range(0, 15) == 0) ? 8'hA5 : 8'h5A;
      if (i % 25 == 0) begin
        m_mode = int'($urandom_range(0, 7));
        wr_reg(2'd0, 32'(m_mode));
      end
      do_cmd({key, 16'(a), c});
    end
    do_cmd(mk(8'h0A, 0));
    do_cmd(mk(8'h0D, 0));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule